// File: doc/BRIEF.md
# Auxiliary Packet Scheduler with Slot RAM

This block stores a handful of auxiliary data packets (video-format and source-description info packets, for example) in a small word-addressed RAM. It sends the enabled packets to a downstream link formatter during blanking, one packet per blanking pulse. Software reaches it through a write-only word bus. A control word holds one enable bit per slot and a master RAM enable. Each slot also has an active flag on a port, and software polls that flag before it rewrites a slot's words.

A slot's active flag follows its enable, with one exception: while the slot's packet is on the wire, the flag stays high until the last byte has gone out. Software can therefore clear an enable, wait for the flag to drop, and then rewrite the words. Writes to a slot whose flag is still high are dropped and raise a sticky error flag. Each packet is 28 bytes long and is streamed one byte per clock. A start marker comes with the first byte and an end marker with the last. The packet type code (0x80 plus the slot index) is carried alongside.

Top module: `hdpkt_scheduler`

## Requirements
- R1: A bus write to word address 0 loads the control word. Bits [7:0] are the per-slot enables and bit 31 is the master enable, and both appear on `slot_en_o`/`ram_en_o` the cycle after the write. Writing 0 clears every enable and the master enable.
- R2: When no transmission is involved, `slot_active_o[s]` equals (enable[s] AND master) delayed by one further cycle. It rises and falls one cycle after the control outputs change.
- R3: While slot s is being transmitted, `slot_active_o[s]` stays 1 through the cycle of its last byte, even if it was disabled meanwhile. It drops on the following cycle.
- R4: Packet word w of slot s lives at bus word address 0x40 + 8*s + w, with w in 0..7.
- R5: Byte 7g+j of a packet comes from word 2g, lane j (bits [8j+7:8j]) for j < 3, and from word 2g+1, lane j-3 for j >= 3. Bits [31:24] of even words are never sent.
- R6: The cycle after a blanking pulse that starts a packet, `pkt_valid_o` is high for exactly 28 consecutive cycles. `pkt_sop_o` is high on the first byte only and `pkt_eop_o` on the last byte only, and `pkt_type_o` = 0x80 + slot.
- R7: A blanking pulse starts the lowest-index slot that is enabled and not yet sent in the current frame. If no slot qualifies, nothing is sent.
- R8: A vertical-sync pulse clears the sent-this-frame marks. A blanking pulse in the same cycle as a vertical-sync pulse already sees them cleared.
- R9: With the master enable clear, no packet starts. A packet already in progress completes all 28 bytes.
- R10: A blanking pulse that arrives while a packet is in progress is ignored and starts nothing later.
- R11: A write to the packet words of a slot whose active flag is 1 leaves the RAM unchanged and sets `wr_err_o`, which stays set until reset.
- R12: After reset all enables, active flags, the error flag and `pkt_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 8 | Bus word address |
| bus_wdata_i | input | 32 | Bus write data |
| vsync_i | input | 1 | Vertical-sync pulse, clears frame marks |
| blank_i | input | 1 | Blanking-opportunity pulse |
| slot_en_o | output | 8 | Per-slot enable bits |
| ram_en_o | output | 1 | Master enable |
| slot_active_o | output | 8 | Per-slot active flags |
| wr_err_o | output | 1 | Sticky dropped-write flag |
| pkt_valid_o | output | 1 | Byte valid |
| pkt_byte_o | output | 8 | Packet byte |
| pkt_sop_o | output | 1 | First byte of packet |
| pkt_eop_o | output | 1 | Last byte of packet |
| pkt_type_o | output | 8 | Type code of packet in flight |

## Verification
The properties assume that `blank_i` and `vsync_i` are synchronous one-cycle pulses. They also assume one bus write per cycle at most, and that nothing disturbs the stream apart from the block's own inputs. The bench drives every input on the falling clock edge. Pulses last exactly one cycle, and bus writes are single-cycle strobes. Random operations (control writes, packet-word writes, sync and blanking pulses) are issued only between packets. Mid-packet blanking pulses, control writes and packet-word writes come only from the directed cases.

// File: rtl/hdpkt_pkg.sv
package hdpkt_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned GROUP_BYTES = 7;   // bytes carried by one word pair
    localparam int unsigned LO_BYTES    = 3;   // bytes held in the even word
    localparam logic [7:0]  TYPE_BASE   = 8'h80;
endpackage

// File: rtl/hdpkt_ram.sv
module hdpkt_ram #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned SLOT_W    = 3,
    parameter int unsigned WORD_W    = 3
) (
    input  logic                       clk_i,
    input  logic                       we_i,
    input  logic [SLOT_W-1:0]          wslot_i,
    input  logic [WORD_W-1:0]          wword_i,
    input  logic [hdpkt_pkg::DATA_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0]          rslot_i,
    input  logic [WORD_W-1:0]          rword_i,
    input  logic [1:0]                 lane_i,
    output logic [7:0]                 byte_o
);
    localparam int unsigned DEPTH = NUM_SLOTS << WORD_W;

    logic [hdpkt_pkg::DATA_W-1:0] mem_q [DEPTH];
    logic [hdpkt_pkg::DATA_W-1:0] rword_d;

    // Storage array: plain write port, no reset on the contents.
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[{wslot_i, wword_i}] <= wdata_i;
        end
    end

    always_comb begin
        rword_d = mem_q[{rslot_i, rword_i}];
        byte_o  = rword_d[{lane_i, 3'b000} +: 8];
    end
endmodule

// File: rtl/hdpkt_slot_ctrl.sv
module hdpkt_slot_ctrl #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned SLOT_W    = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cfg_we_i,
    input  logic [NUM_SLOTS-1:0] cfg_en_i,
    input  logic                 cfg_glb_i,
    input  logic                 ram_req_i,
    input  logic [SLOT_W-1:0]    ram_slot_i,
    input  logic                 vsync_i,
    input  logic                 blank_i,
    input  logic                 busy_i,
    input  logic [SLOT_W-1:0]    cur_i,
    input  logic                 last_i,
    output logic [NUM_SLOTS-1:0] en_o,
    output logic                 glb_o,
    output logic [NUM_SLOTS-1:0] act_o,
    output logic                 err_o,
    output logic                 ram_ok_o,
    output logic                 start_o,
    output logic [SLOT_W-1:0]    start_slot_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] en;
        logic                 glb;
        logic [NUM_SLOTS-1:0] act;
        logic [NUM_SLOTS-1:0] sent;
        logic                 err;
    } ctrl_t;

    ctrl_t                st_d, st_q;
    logic [NUM_SLOTS-1:0] en_eff, sent_base, cand;
    logic [SLOT_W-1:0]    pick;
    logic                 start;

    always_comb begin
        st_d   = st_q;
        en_eff = st_q.en & {NUM_SLOTS{st_q.glb}};
        if (cfg_we_i) begin
            st_d.en  = cfg_en_i;
            st_d.glb = cfg_glb_i;
        end
        // Active flag follows the effective enable except for the slot on
        // the wire, which is held until its final byte has been sent.
        for (int s = 0; s < NUM_SLOTS; s++) begin
            st_d.act[s] = en_eff[s] | (busy_i && (cur_i == SLOT_W'(s)) && !last_i);
        end
        sent_base = vsync_i ? '0 : st_q.sent;
        cand      = en_eff & ~sent_base;
        pick      = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (cand[s]) pick = SLOT_W'(s);
        end
        start     = blank_i && !busy_i && (|cand);
        st_d.sent = sent_base;
        if (start) st_d.sent[pick] = 1'b1;
        ram_ok_o = ram_req_i && !st_q.act[ram_slot_i];
        if (ram_req_i && st_q.act[ram_slot_i]) st_d.err = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o         = st_q.en;
    assign glb_o        = st_q.glb;
    assign act_o        = st_q.act;
    assign err_o        = st_q.err;
    assign start_o      = start;
    assign start_slot_o = pick;
endmodule

// File: rtl/hdpkt_streamer.sv
module hdpkt_streamer #(
    parameter int unsigned GROUPS = 4,
    parameter int unsigned SLOT_W = 3,
    parameter int unsigned GRP_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] start_slot_i,
    output logic              busy_o,
    output logic [SLOT_W-1:0] cur_o,
    output logic              last_o,
    output logic              sop_o,
    output logic [GRP_W:0]    word_o,
    output logic [1:0]        lane_o
);
    localparam logic [2:0]       POS_LAST = 3'(hdpkt_pkg::GROUP_BYTES - 1);
    localparam logic [2:0]       POS_HI   = 3'(hdpkt_pkg::LO_BYTES);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUPS - 1);

    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] cur;
        logic [GRP_W-1:0]  grp;
        logic [2:0]        pos;
    } strm_t;

    strm_t st_d, st_q;
    logic  last;
    logic  hi;

    always_comb begin
        st_d = st_q;
        last = st_q.busy && (st_q.grp == GRP_LAST) && (st_q.pos == POS_LAST);
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cur  = start_slot_i;
            st_d.grp  = '0;
            st_d.pos  = '0;
        end else if (st_q.busy) begin
            if (last) begin
                st_d.busy = 1'b0;
            end else if (st_q.pos == POS_LAST) begin
                st_d.pos = '0;
                st_d.grp = st_q.grp + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        hi     = (st_q.pos >= POS_HI);
        word_o = {st_q.grp, hi};
        lane_o = hi ? 2'(st_q.pos - POS_HI) : st_q.pos[1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign cur_o  = st_q.cur;
    assign last_o = last;
    assign sop_o  = st_q.busy && (st_q.grp == '0) && (st_q.pos == '0);
endmodule

// File: rtl/hdpkt_scheduler.sv
module hdpkt_scheduler #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned GROUPS    = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned RAM_BASE  = 64,
    parameter int unsigned CFG_ADDR  = 0,
    parameter int unsigned GLB_BIT   = 31
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          bus_we_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [hdpkt_pkg::DATA_W-1:0]  bus_wdata_i,
    input  logic                          vsync_i,
    input  logic                          blank_i,
    output logic [NUM_SLOTS-1:0]          slot_en_o,
    output logic                          ram_en_o,
    output logic [NUM_SLOTS-1:0]          slot_active_o,
    output logic                          wr_err_o,
    output logic                          pkt_valid_o,
    output logic [7:0]                    pkt_byte_o,
    output logic                          pkt_sop_o,
    output logic                          pkt_eop_o,
    output logic [7:0]                    pkt_type_o
);
    localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int unsigned GRP_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int unsigned WORD_W    = GRP_W + 1;
    localparam int unsigned RAM_WORDS = NUM_SLOTS << WORD_W;

    logic [ADDR_W-1:0] offs;
    logic              cfg_we, ram_req, ram_ok;
    logic              busy, last, start;
    logic [SLOT_W-1:0] cur, start_slot;
    logic [WORD_W-1:0] rword;
    logic [1:0]        lane;

    // Slot base = RAM_BASE + stride * slot; stride is 2**WORD_W words.
    assign offs    = bus_addr_i - ADDR_W'(RAM_BASE);
    assign cfg_we  = bus_we_i && (bus_addr_i == ADDR_W'(CFG_ADDR));
    assign ram_req = bus_we_i && (32'(offs) < RAM_WORDS);

    hdpkt_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_we_i     (cfg_we),
        .cfg_en_i     (bus_wdata_i[NUM_SLOTS-1:0]),
        .cfg_glb_i    (bus_wdata_i[GLB_BIT]),
        .ram_req_i    (ram_req),
        .ram_slot_i   (offs[WORD_W +: SLOT_W]),
        .vsync_i      (vsync_i),
        .blank_i      (blank_i),
        .busy_i       (busy),
        .cur_i        (cur),
        .last_i       (last),
        .en_o         (slot_en_o),
        .glb_o        (ram_en_o),
        .act_o        (slot_active_o),
        .err_o        (wr_err_o),
        .ram_ok_o     (ram_ok),
        .start_o      (start),
        .start_slot_o (start_slot)
    );

    hdpkt_streamer #(.GROUPS(GROUPS), .SLOT_W(SLOT_W), .GRP_W(GRP_W)) u_strm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start),
        .start_slot_i (start_slot),
        .busy_o       (busy),
        .cur_o        (cur),
        .last_o       (last),
        .sop_o        (pkt_sop_o),
        .word_o       (rword),
        .lane_o       (lane)
    );

    hdpkt_ram #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_ram (
        .clk_i   (clk_i),
        .we_i    (ram_ok),
        .wslot_i (offs[WORD_W +: SLOT_W]),
        .wword_i (offs[WORD_W-1:0]),
        .wdata_i (bus_wdata_i),
        .rslot_i (cur),
        .rword_i (rword),
        .lane_i  (lane),
        .byte_o  (pkt_byte_o)
    );

    assign pkt_valid_o = busy;
    assign pkt_eop_o   = last;
    assign pkt_type_o  = hdpkt_pkg::TYPE_BASE + 8'(cur);
endmodule

// File: rtl/hdpkt_checker.sv
module hdpkt_checker #(
    parameter int unsigned NUM_SLOTS = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 blank_i,
    input logic                 pkt_valid_o,
    input logic                 pkt_sop_o,
    input logic                 pkt_eop_o,
    input logic [7:0]           pkt_type_o,
    input logic [NUM_SLOTS-1:0] slot_active_o,
    input logic                 wr_err_o,
    input logic                 ram_en_o
);
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [7:0] type_idx;
    assign type_idx = pkt_type_o - hdpkt_pkg::TYPE_BASE;

    p_sop_after_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_sop_o |-> (pkt_valid_o && $past(blank_i)));

    p_eop_then_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_eop_o |=> !pkt_valid_o);

    p_type_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_valid_o && !pkt_eop_o) |=> (pkt_valid_o && $stable(pkt_type_o)));

    p_active_in_flight_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o |-> slot_active_o[type_idx[SLOT_W-1:0]]);

    p_blank_ignored_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_valid_o && blank_i) |=> !pkt_sop_o);

    p_no_start_master_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ram_en_o && !pkt_valid_o) |=> !pkt_valid_o);

    p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_err_o |=> wr_err_o);
endmodule

bind hdpkt_scheduler hdpkt_checker #(.NUM_SLOTS(NUM_SLOTS)) u_hdpkt_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .blank_i       (blank_i),
    .pkt_valid_o   (pkt_valid_o),
    .pkt_sop_o     (pkt_sop_o),
    .pkt_eop_o     (pkt_eop_o),
    .pkt_type_o    (pkt_type_o),
    .slot_active_o (slot_active_o),
    .wr_err_o      (wr_err_o),
    .ram_en_o      (ram_en_o)
);

// File: tb/test_hdpkt_scheduler.sv
module test_hdpkt_scheduler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        vsync = 1'b0;
    logic        blank = 1'b0;
    logic [7:0]  slot_en, slot_act, pkt_byte, pkt_type;
    logic        ram_en, wr_err, pkt_valid, pkt_sop, pkt_eop;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem_m [64];
    logic [7:0]  en_m   = '0;
    logic        glb_m  = 1'b0;
    logic [7:0]  sent_m = '0;
    logic        err_m  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hdpkt_scheduler i_hdpkt_scheduler (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .vsync_i(vsync), .blank_i(blank),
        .slot_en_o(slot_en), .ram_en_o(ram_en), .slot_active_o(slot_act),
        .wr_err_o(wr_err), .pkt_valid_o(pkt_valid), .pkt_byte_o(pkt_byte),
        .pkt_sop_o(pkt_sop), .pkt_eop_o(pkt_eop), .pkt_type_o(pkt_type)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5: byte 7g+j from word 2g lane j (j<3) or word 2g+1 lane j-3.
    function automatic logic [7:0] exp_byte(input int slot, input int k);
        int g = k / 7;
        int j = k % 7;
        int w = (j < 3) ? 2 * g : 2 * g + 1;
        int l = (j < 3) ? j : j - 3;
        return mem_m[slot * 8 + w][l * 8 +: 8];
    endfunction

    // R7: lowest enabled slot not yet sent, only under master enable.
    function automatic int pick_slot(input logic [7:0] en, input logic g, input logic [7:0] sent);
        if (!g) return -1;
        for (int s = 0; s < 8; s++) if (en[s] && !sent[s]) return s;
        return -1;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] en, input logic g);
        bus_write(8'h00, {g, 23'd0, en});
        en_m = en; glb_m = g;
    endtask

    task automatic pulse(input logic b, input logic v);
        blank = b; vsync = v;
        @(negedge clk);
        blank = 1'b0; vsync = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        int bad = 0;
        for (int i = 0; i < 3; i++) begin
            if (pkt_valid) bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Called at the falling edge after the starting blank pulse (R6).
    task automatic stream_check(input int slot, input int wr_k, input logic [7:0] wr_a,
                                input logic [31:0] wr_d, input int blank_k,
                                input bit act_after, input string req);
        int bad = 0;
        logic [63:0] act_v = '0, exp_v = '0;
        for (int k = 0; k < 28; k++) begin
            if (!pkt_valid || pkt_byte !== exp_byte(slot, k) || pkt_sop !== (k == 0) ||
                pkt_eop !== (k == 27) || pkt_type !== 8'(8'h80 + slot) || !slot_act[slot]) begin
                if (bad == 0) begin
                    act_v = {k[7:0], pkt_valid, pkt_sop, pkt_eop, slot_act[slot], pkt_type, pkt_byte};
                    exp_v = {k[7:0], 1'b1, k == 0, k == 27, 1'b1, 8'(8'h80 + slot), exp_byte(slot, k)};
                end
                bad++;
            end
            if (k == wr_k) begin we = 1'b1; addr = wr_a; wdata = wr_d; end
            if (k == wr_k + 1) we = 1'b0;
            if (k == blank_k) blank = 1'b1;
            if (k == blank_k + 1) blank = 1'b0;
            @(negedge clk);
        end
        chk(bad == 0, {req, " stream bytes/markers"}, act_v, exp_v);
        chk(!pkt_valid && slot_act[slot] == act_after, {req, " R3 end of packet"},
            {pkt_valid, slot_act[slot]}, {1'b0, act_after});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R12 reset state
        chk(slot_en == 0 && !ram_en && slot_act == 0 && !wr_err && !pkt_valid, "R12 reset",
            {slot_en, ram_en, slot_act, wr_err, pkt_valid}, 0);

        // R4: fill every slot while all are idle
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 8; w++) begin
                logic [31:0] d = $urandom;
                bus_write(8'(8'h40 + s * 8 + w), d);
                mem_m[s * 8 + w] = d;
            end
        chk(!wr_err, "R11 no error on idle writes", wr_err, 0);

        // R1 / R2 timing
        set_cfg(8'h05, 1'b1);
        chk(slot_en == 8'h05 && ram_en, "R1 control word", {slot_en, ram_en}, {8'h05, 1'b1});
        chk(slot_act == 8'h00, "R2 active lags one cycle", slot_act, 0);
        tick();
        chk(slot_act == 8'h05, "R2 active follows enable", slot_act, 8'h05);

        // R7 order, R4/R5/R6 content
        pulse(1, 0); stream_check(0, -9, 0, 0, -9, 1, "R7 first slot0");
        pulse(1, 0); stream_check(2, -9, 0, 0, -9, 1, "R7 next slot2");
        pulse(1, 0); expect_idle("R7 nothing left");
        // R8
        pulse(0, 1); pulse(1, 0); stream_check(0, -9, 0, 0, -9, 1, "R8 vsync clears");
        pulse(1, 1); stream_check(0, -9, 0, 0, -9, 1, "R8 same-cycle vsync");
        // R10: blank mid-packet while slot2 pending
        pulse(0, 1); pulse(1, 0); stream_check(0, -9, 0, 0, 10, 1, "R10 slot0");
        expect_idle("R10 mid-packet blank ignored");
        pulse(1, 0); stream_check(2, -9, 0, 0, -9, 1, "R10 slot2 later");

        // R11: write to active slot0 during its packet is dropped
        pulse(0, 1); pulse(1, 0);
        stream_check(0, 5, 8'h40, ~mem_m[0], -9, 1, "R11 slot0");
        chk(wr_err, "R11 error set", wr_err, 1);
        begin
            logic [31:0] d = $urandom;
            bus_write(8'h58, d);            // slot3 word0, slot3 idle
            mem_m[24] = d;
        end
        err_m = 1'b1;
        pulse(0, 1); pulse(1, 0); stream_check(0, -9, 0, 0, -9, 1, "R11 RAM unchanged");
        chk(wr_err, "R11 error sticky", wr_err, 1);

        // R2 fall, R3 / R9 in-flight disable
        set_cfg(8'h08, 1'b1); tick();
        chk(slot_act == 8'h08, "R2 active falls when idle", slot_act, 8'h08);
        pulse(0, 1); pulse(1, 0);
        stream_check(3, 5, 8'h00, 32'h0, -9, 0, "R3 disable in flight");
        en_m = '0; glb_m = 1'b0;
        chk(slot_en == 0 && !ram_en && slot_act == 0, "R1 zero write clears",
            {slot_en, ram_en, slot_act}, 0);
        set_cfg(8'hFF, 1'b0); tick();
        chk(slot_act == 0, "R9 master off no active", slot_act, 0);
        pulse(1, 1); expect_idle("R9 master off no start");

        // Random phase
        set_cfg(8'h00, 1'b1); tick();
        sent_m = '0; pulse(0, 1);
        for (int it = 0; it < 60; it++) begin
            int op = $urandom_range(0, 3);
            if (op == 0) begin
                logic [7:0] e = 8'($urandom);
                logic g = ($urandom_range(0, 3) != 0);
                set_cfg(e, g); tick();
                chk(slot_act == (e & {8{g}}), "R2 random active", slot_act, e & {8{g}});
            end else if (op == 1) begin
                int s = $urandom_range(0, 7);
                int w = $urandom_range(0, 7);
                logic [31:0] d = $urandom;
                bit ok = !(en_m[s] && glb_m);
                bus_write(8'(8'h40 + s * 8 + w), d);
                if (ok) mem_m[s * 8 + w] = d; else err_m = 1'b1;
                chk(wr_err == err_m, "R11 random write", wr_err, err_m);
            end else if (op == 2) begin
                pulse(0, 1); sent_m = '0;
            end else begin
                logic v = ($urandom_range(0, 3) == 0);
                int p;
                if (v) sent_m = '0;
                p = pick_slot(en_m, glb_m, sent_m);
                pulse(1, v);
                if (p >= 0) begin
                    stream_check(p, -9, 0, 0, -9, 1, "R7 random packet");
                    sent_m[p] = 1'b1;
                end else begin
                    expect_idle("R7 random idle");
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule